// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block sits between a stream of memory requests and a multi-bank DRAM rank. Each request names a bank, a row and a direction. Requests wait in a small queue that keeps them in the order they arrived. Every clock cycle the scheduler looks at the queue and at the row that is open in each bank, and chooses at most one DRAM command to send. A request whose row is already open in its bank is served before any older request that would first need a row change. If no queued request hits an open row, the oldest request in the queue is advanced one step.

The command for a request depends on the state of its bank. A request to a closed bank gets an activate, and then a read or write. A request that conflicts with a different open row gets a precharge first. After a read or write, the row stays open (open-page policy). A free-running refresh timer raises a refresh need on a fixed period. Normal traffic then stops, every open bank is closed one per cycle, and a refresh command goes out. No command follows for a fixed busy time.

Top module: `dram_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cmd_valid` is 0, the queue is empty and `enq_ready` is 1. All banks start closed.
- R2: A queued request whose bank holds its row open is served by one column command, with no activate or precharge: `cmd_op` 3 (read) when `enq_write` was 0, or 4 (write) when it was 1. The command carries the request's bank and row.
- R3: When the oldest request targets a closed bank and no request hits, the scheduler issues an activate (`cmd_op` 1) with the request's bank and row, then the column command.
- R4: When the oldest request targets a bank that has a different row open and no request hits, the scheduler issues a precharge (`cmd_op` 2, `cmd_row` 0), then an activate, then the column command.
- R5: A row stays open after a column command, so a later request to the same bank and row is served as in R2.
- R6: A row-hit request is issued ahead of an older request that does not hit.
- R7: If several queued requests hit, the oldest of them goes first. If none hits, the oldest request in the queue is advanced.
- R8: At most one command is issued per cycle. The command appears on the output ports one cycle after the decision, and a request can be chosen from the cycle after it is enqueued.
- R9: Every REF_INTERVAL cycles a refresh becomes due, and it takes priority over queued requests. Open banks are precharged one per cycle, lowest bank index first. Then a refresh command is issued (`cmd_op` 5, `cmd_bank` 0, `cmd_row` 0).
- R10: After a refresh command, no command is issued for REF_BUSY cycles, even when requests are waiting.
- R11: The queue holds QDEPTH requests. When it is full, `enq_ready` is 0 and an enqueue is dropped and never served.

Operation codes not listed above are unused. Code 0 means no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Request present this cycle |
| enq_bank | input | $clog2(NUM_BANKS) | Target bank of the request |
| enq_row | input | ROW_W | Target row of the request |
| enq_write | input | 1 | 1 for a write, 0 for a read |
| enq_ready | output | 1 | Queue has a free slot |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | Command code (1 activate, 2 precharge, 3 read, 4 write, 5 refresh) |
| cmd_bank | output | $clog2(NUM_BANKS) | Bank of the command |
| cmd_row | output | ROW_W | Row for activate, read and write; 0 for precharge and refresh |

## Verification
The assertions assume that NUM_BANKS is a power of two, so every bank field names a real bank. They also assume that the refresh interval is longer than the refresh busy time plus the cycles needed to close all banks, so a new refresh cannot come due while one is still in progress.

The stimulus uses only four banks with eight-bit rows. It always holds reset at 0 from time zero. It keeps its directed traffic well inside one refresh period, except for the single test that waits for a refresh on purpose. Its only enqueue attempt on a full queue is made during refresh busy time, when the expected drain order is fully known.

// File: rtl/dram_sched_pkg.sv
// Package: shared command encoding for the DRAM command scheduler.
// Assumes a 3-bit command field on the command port.
package dram_sched_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ACT    = 3'd1,
        OP_PRE    = 3'd2,
        OP_READ   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_REFR   = 3'd5
    } dram_op_e;

endpackage

// File: rtl/dram_req_queue.sv
// Module: arrival-ordered request queue. Slot 0 always holds the oldest
// request. Any slot may be removed; the younger slots shift down to fill
// the gap. A push is accepted only while a free slot exists, so a push
// while full is dropped. Assumes pop_idx points at a valid slot when pop is set.
module dram_req_queue #(
    parameter  int DEPTH  = 8,
    parameter  int BANK_W = 3,
    parameter  int ROW_W  = 14,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [ROW_W-1:0]  push_row,
    input  logic              push_wr,
    input  logic              pop,
    input  logic [IDX_W-1:0]  pop_idx,
    output logic              full,
    output logic [CNT_W-1:0]  count,
    output logic [DEPTH-1:0]  slot_valid,
    output logic [BANK_W-1:0] slot_bank [DEPTH],
    output logic [ROW_W-1:0]  slot_row  [DEPTH],
    output logic [DEPTH-1:0]  slot_wr
);

    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [DEPTH-1:0]  wr_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [BANK_W-1:0] bank_n [DEPTH];
    logic [ROW_W-1:0]  row_n  [DEPTH];
    logic [DEPTH-1:0]  wr_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [CNT_W-1:0]  cnt_left;
    logic              push_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign push_ok = push && !full;

    // Expose the slots and mark the occupied ones.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_valid[i] = (i < int'(cnt_q));
            slot_bank[i]  = bank_q[i];
            slot_row[i]   = row_q[i];
        end
        slot_wr = wr_q;
    end

    // Next state: close the gap left by a removal, then append a push.
    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop && i >= int'(pop_idx)) begin
                bank_n[i] = bank_q[i+1];
                row_n[i]  = row_q[i+1];
                wr_n[i]   = wr_q[i+1];
            end else begin
                bank_n[i] = bank_q[i];
                row_n[i]  = row_q[i];
                wr_n[i]   = wr_q[i];
            end
        end
        bank_n[DEPTH-1] = bank_q[DEPTH-1];
        row_n[DEPTH-1]  = row_q[DEPTH-1];
        wr_n[DEPTH-1]   = wr_q[DEPTH-1];
        cnt_left = cnt_q - CNT_W'(pop);
        if (push_ok) begin
            bank_n[IDX_W'(cnt_left)] = push_bank;
            row_n[IDX_W'(cnt_left)]  = push_row;
            wr_n[IDX_W'(cnt_left)]   = push_wr;
        end
        cnt_n = cnt_left + CNT_W'(push_ok);
    end

    // Register the queue contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wr_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= '0;
                row_q[i]  <= '0;
            end
        end else begin
            cnt_q <= cnt_n;
            wr_q  <= wr_n;
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= bank_n[i];
                row_q[i]  <= row_n[i];
            end
        end
    end

endmodule

// File: rtl/dram_bank_state.sv
// Module: per-bank open-row tracker. Each bank has one row buffer that is
// either closed or holds the last activated row. An activate opens a row
// and a precharge closes it. Assumes act and pre are never set together.
module dram_bank_state #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act,
    input  logic                 pre,
    input  logic [BANK_W-1:0]    sel_bank,
    input  logic [ROW_W-1:0]     act_row,
    output logic [NUM_BANKS-1:0] is_open,
    output logic [ROW_W-1:0]     row_of [NUM_BANKS]
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Track the open/closed state and the open row of one bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                is_open[b] <= 1'b0;
                row_of[b]  <= '0;
            end else if (act && sel_bank == BANK_W'(b)) begin
                is_open[b] <= 1'b1;
                row_of[b]  <= act_row;
            end else if (pre && sel_bank == BANK_W'(b)) begin
                is_open[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dram_refresh_timer.sv
// Module: refresh pacing. A free-running counter marks a refresh as due once
// per INTERVAL cycles. The due flag stays set until a refresh command is
// issued. After that command, busy stays high for BUSY cycles.
// Assumes INTERVAL is greater than BUSY plus the number of banks.
module dram_refresh_timer #(
    parameter  int INTERVAL = 780,
    parameter  int BUSY     = 35,
    localparam int TICK_W   = $clog2(INTERVAL),
    localparam int BUSY_W   = $clog2(BUSY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_fire,
    output logic due,
    output logic busy
);

    logic [TICK_W-1:0] tick_q;
    logic [BUSY_W-1:0] busy_q;
    logic              due_q;
    logic              wrap;

    assign wrap = (tick_q == TICK_W'(INTERVAL - 1));
    assign due  = due_q;
    assign busy = (busy_q != '0);

    // Count the refresh period.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) tick_q <= '0;
        else                tick_q <= tick_q + 1'b1;
    end

    // Hold the refresh need until the refresh command goes out.
    always_ff @(posedge clk) begin
        if (!rst_n)        due_q <= 1'b0;
        else if (ref_fire) due_q <= 1'b0;
        else if (wrap)     due_q <= 1'b1;
    end

    // Count down the time the rank is unavailable after a refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)            busy_q <= '0;
        else if (ref_fire)     busy_q <= BUSY_W'(BUSY);
        else if (busy_q != '0) busy_q <= busy_q - 1'b1;
    end

endmodule

// File: rtl/dram_sched.sv
// Module: row-hit-first DRAM command scheduler (top). Each cycle it picks at
// most one command. Priority is: refresh busy time (no command), then a due
// refresh (close open banks, then refresh), then the oldest queued row hit
// (column command), then the oldest request (precharge or activate).
// Commands are registered, so they appear one cycle after the decision.
// Assumes NUM_BANKS is a power of two.
module dram_sched
    import dram_sched_pkg::*;
#(
    parameter  int NUM_BANKS    = 8,
    parameter  int ROW_W        = 14,
    parameter  int QDEPTH       = 8,
    parameter  int REF_INTERVAL = 780,
    parameter  int REF_BUSY     = 35,
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int IDX_W        = $clog2(QDEPTH),
    localparam int CNT_W        = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic              enq_write,
    output logic              enq_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row
);

    logic              q_full;
    logic [CNT_W-1:0]  q_count;
    logic [QDEPTH-1:0] slot_valid;
    logic [BANK_W-1:0] slot_bank [QDEPTH];
    logic [ROW_W-1:0]  slot_row  [QDEPTH];
    logic [QDEPTH-1:0] slot_wr;

    logic [NUM_BANKS-1:0] bank_open;
    logic [ROW_W-1:0]     row_of [NUM_BANKS];

    logic ref_due, ref_busy;

    logic [QDEPTH-1:0] hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [BANK_W-1:0] low_open;

    dram_op_e          nxt_op;
    logic [BANK_W-1:0] nxt_bank;
    logic [ROW_W-1:0]  nxt_row;
    logic              do_pop, do_act, do_pre, do_ref;

    assign enq_ready = !q_full;

    dram_req_queue #(.DEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(enq_valid), .push_bank(enq_bank), .push_row(enq_row), .push_wr(enq_write),
        .pop(do_pop), .pop_idx(hit_idx),
        .full(q_full), .count(q_count),
        .slot_valid(slot_valid), .slot_bank(slot_bank), .slot_row(slot_row), .slot_wr(slot_wr)
    );

    dram_bank_state #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .act(do_act), .pre(do_pre), .sel_bank(nxt_bank), .act_row(nxt_row),
        .is_open(bank_open), .row_of(row_of)
    );

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL), .BUSY(REF_BUSY)) u_refresh (
        .clk(clk), .rst_n(rst_n), .ref_fire(do_ref), .due(ref_due), .busy(ref_busy)
    );

    // Mark queued requests whose row is open in their bank; find the oldest.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            hit[i] = slot_valid[i] && bank_open[slot_bank[i]]
                     && (row_of[slot_bank[i]] == slot_row[i]);
        end
        for (int i = QDEPTH - 1; i >= 0; i--) begin
            if (hit[i]) hit_idx = IDX_W'(i);
        end
    end

    // Find the lowest-numbered open bank for refresh closing.
    always_comb begin
        low_open = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bank_open[b]) low_open = BANK_W'(b);
        end
    end

    // Choose this cycle's command and its side effects.
    always_comb begin
        nxt_op   = OP_NONE;
        nxt_bank = '0;
        nxt_row  = '0;
        do_pop   = 1'b0;
        do_act   = 1'b0;
        do_pre   = 1'b0;
        do_ref   = 1'b0;
        if (ref_busy) begin
            nxt_op = OP_NONE;
        end else if (ref_due) begin
            if (|bank_open) begin
                nxt_op   = OP_PRE;
                nxt_bank = low_open;
                do_pre   = 1'b1;
            end else begin
                nxt_op = OP_REFR;
                do_ref = 1'b1;
            end
        end else if (|hit) begin
            nxt_op   = slot_wr[hit_idx] ? OP_WRITE : OP_READ;
            nxt_bank = slot_bank[hit_idx];
            nxt_row  = slot_row[hit_idx];
            do_pop   = 1'b1;
        end else if (slot_valid[0]) begin
            nxt_bank = slot_bank[0];
            if (bank_open[slot_bank[0]]) begin
                nxt_op = OP_PRE;
                do_pre = 1'b1;
            end else begin
                nxt_op  = OP_ACT;
                nxt_row = slot_row[0];
                do_act  = 1'b1;
            end
        end
    end

    // Register the command port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
            cmd_bank  <= '0;
            cmd_row   <= '0;
        end else begin
            cmd_valid <= (nxt_op != OP_NONE);
            cmd_op    <= nxt_op;
            cmd_bank  <= nxt_bank;
            cmd_row   <= nxt_row;
        end
    end

endmodule

// File: rtl/dram_sched_chk.sv
// Module: assertion checker for the scheduler, bound to the top module.
// Assumes the bank field always names an existing bank.
module dram_sched_chk #(
    parameter  int NUM_BANKS = 8,
    parameter  int ROW_W     = 14,
    parameter  int QDEPTH    = 8,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int CNT_W     = $clog2(QDEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enq_ready,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [ROW_W-1:0]     cmd_row,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [ROW_W-1:0]     row_of [NUM_BANKS],
    input logic [CNT_W-1:0]     occ
);

    logic is_col, is_act, is_pre, is_ref;
    assign is_col = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4);
    assign is_act = cmd_valid && cmd_op == 3'd1;
    assign is_pre = cmd_valid && cmd_op == 3'd2;
    assign is_ref = cmd_valid && cmd_op == 3'd5;

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && enq_ready && occ == '0));

    a_r2_col_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (bank_open[cmd_bank] && row_of[cmd_bank] == cmd_row));

    a_r3_act_opens_row: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (bank_open[cmd_bank] && row_of[cmd_bank] == cmd_row));

    a_r4_pre_closes_bank: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (!bank_open[cmd_bank] && cmd_row == '0));

    a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op >= 3'd1 && cmd_op <= 3'd5));

    a_r9_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (bank_open == '0 && cmd_bank == '0));

    a_r10_idle_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> !cmd_valid);

    a_r11_occupancy_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (occ <= CNT_W'(QDEPTH)) && ((occ == CNT_W'(QDEPTH)) == !enq_ready));

endmodule

bind dram_sched dram_sched_chk #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .QDEPTH(QDEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .bank_open(bank_open), .row_of(row_of), .occ(q_count)
);

// File: tb/dram_sched_bench.sv
// Bench: a table of single requests with their expected command sequence,
// then directed tests for reset, hit priority, refresh and a full queue.
module dram_sched_bench;

    localparam int NB = 4;
    localparam int RW = 8;
    localparam int QD = 8;
    localparam int RI = 400;
    localparam int RB = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic [1:0] enq_bank = '0;
    logic [RW-1:0] enq_row = '0;
    logic enq_write = 1'b0;
    logic enq_ready, cmd_valid;
    logic [2:0] cmd_op;
    logic [1:0] cmd_bank;
    logic [RW-1:0] cmd_row;

    always #5 clk = ~clk;

    dram_sched #(.NUM_BANKS(NB), .ROW_W(RW), .QDEPTH(QD),
                 .REF_INTERVAL(RI), .REF_BUSY(RB)) u_dram_sched (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_write(enq_write), .enq_ready(enq_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [2:0]    log_op   [0:255];
    logic [1:0]    log_bank [0:255];
    logic [RW-1:0] log_row  [0:255];
    int log_n = 0;

    logic [2:0]    exp_op   [0:15];
    logic [1:0]    exp_bank [0:15];
    logic [RW-1:0] exp_row  [0:15];

    // Each vector: {bank, row, write, kind}; kind 0 hit, 1 closed bank, 2 conflict.
    localparam logic [12:0] TBL [0:9] = '{
        {2'd0, 8'd5,   1'b0, 2'd1},
        {2'd0, 8'd5,   1'b1, 2'd0},
        {2'd1, 8'd3,   1'b0, 2'd1},
        {2'd0, 8'd7,   1'b0, 2'd2},
        {2'd1, 8'd3,   1'b1, 2'd0},
        {2'd3, 8'd255, 1'b0, 2'd1},
        {2'd0, 8'd7,   1'b0, 2'd0},
        {2'd1, 8'd9,   1'b1, 2'd2},
        {2'd2, 8'd0,   1'b0, 2'd1},
        {2'd3, 8'd255, 1'b1, 2'd0}
    };

    // Record every issued command shortly after the clock edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && cmd_valid && log_n < 256) begin
            log_op[log_n]   = cmd_op;
            log_bank[log_n] = cmd_bank;
            log_row[log_n]  = cmd_row;
            log_n++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push(input logic [1:0] b, input logic [RW-1:0] r, input logic w);
        enq_valid = 1'b1;
        enq_bank  = b;
        enq_row   = r;
        enq_write = w;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic set_exp(input int k, input logic [2:0] op, input logic [1:0] b,
                           input logic [RW-1:0] r);
        exp_op[k]   = op;
        exp_bank[k] = b;
        exp_row[k]  = r;
    endtask

    task automatic cmp_seq(input int start, input int n, input string tag);
        int bad;
        int got;
        bad = -1;
        got = log_n - start;
        checks++;
        for (int k = 0; k < n; k++) begin
            if (bad < 0 && (start + k >= log_n || log_op[start+k] !== exp_op[k] ||
                log_bank[start+k] !== exp_bank[k] || log_row[start+k] !== exp_row[k]))
                bad = k;
        end
        if (bad < 0 && got != n) bad = n;
        if (bad >= 0) begin
            errors++;
            if (start + bad < log_n)
                $display("FAIL %s: item %0d got op=%0d bank=%0d row=%0d (%0d cmds), expected op=%0d bank=%0d row=%0d (%0d cmds)",
                         tag, bad, log_op[start+bad], log_bank[start+bad], log_row[start+bad],
                         got, exp_op[bad], exp_bank[bad], exp_row[bad], n);
            else
                $display("FAIL %s: item %0d missing (%0d cmds), expected op=%0d bank=%0d row=%0d (%0d cmds)",
                         tag, bad, got, exp_op[bad], exp_bank[bad], exp_row[bad], n);
        end
    endtask

    task automatic check_bit(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
        end
    endtask

    initial begin
        int ref_i;
        int ncol;
        bit seen;
        // R1: quiet state while reset is held.
        repeat (3) @(negedge clk);
        check_bit(cmd_valid, 1'b0, "R1 cmd_valid in reset");
        check_bit(enq_ready, 1'b1, "R1 enq_ready in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // Table: one request at a time, whole command sequence compared.
        for (int v = 0; v < 10; v++) begin
            logic [12:0] e;
            int st;
            int k;
            string tag;
            e  = TBL[v];
            st = log_n;
            push(e[12:11], e[10:3], e[2]);
            repeat (8) @(negedge clk);
            k = 0;
            if (e[1:0] == 2'd2) begin set_exp(k, 3'd2, e[12:11], '0); k++; end
            if (e[1:0] != 2'd0) begin set_exp(k, 3'd1, e[12:11], e[10:3]); k++; end
            set_exp(k, e[2] ? 3'd4 : 3'd3, e[12:11], e[10:3]); k++;
            tag = (e[1:0] == 2'd0) ? "R2 R5 row hit" :
                  (e[1:0] == 2'd1) ? "R3 closed bank" : "R4 row conflict";
            cmp_seq(st, k, $sformatf("%s vector %0d", tag, v));
        end

        // R6, R8: a conflict enqueued one cycle before a hit; the hit
        // overtakes it after the conflict's precharge.
        begin
            int st;
            st = log_n;
            push(2'd0, 8'd1, 1'b0);
            push(2'd1, 8'd9, 1'b0);
            repeat (8) @(negedge clk);
            set_exp(0, 3'd2, 2'd0, 8'd0);
            set_exp(1, 3'd3, 2'd1, 8'd9);
            set_exp(2, 3'd1, 2'd0, 8'd1);
            set_exp(3, 3'd3, 2'd0, 8'd1);
            cmp_seq(st, 4, "R6 R8 hit before older conflict");
        end

        // R9: wait for the refresh; all four banks are open at that point.
        seen = 1'b0;
        for (int t = 0; t < 600 && !seen; t++) begin
            @(negedge clk);
            if (log_n > 0 && log_op[log_n-1] == 3'd5) seen = 1'b1;
        end
        check_bit(seen, 1'b1, "R9 refresh issued");
        ref_i = log_n - 1;
        if (seen && ref_i >= 4) begin
            for (int b = 0; b < 4; b++) set_exp(b, 3'd2, 2'(b), 8'd0);
            set_exp(4, 3'd5, 2'd0, 8'd0);
            cmp_seq(ref_i - 4, 5, "R9 close banks then refresh");
        end

        // Fill the queue during refresh busy time (R10, R11).
        push(2'd0, 8'd2, 1'b0);
        push(2'd0, 8'd2, 1'b1);
        push(2'd1, 8'd2, 1'b0);
        push(2'd1, 8'd6, 1'b0);
        push(2'd1, 8'd2, 1'b1);
        push(2'd2, 8'd1, 1'b0);
        push(2'd0, 8'd2, 1'b0);
        push(2'd3, 8'd3, 1'b1);
        check_bit(enq_ready, 1'b0, "R11 enq_ready low when full");
        push(2'd3, 8'd4, 1'b0);
        repeat (3) @(negedge clk);
        check_int(log_n - ref_i - 1, 0, "R10 no command during refresh busy");

        // R7: oldest of several hits first; oldest overall when none hit.
        repeat (25) @(negedge clk);
        set_exp(0,  3'd1, 2'd0, 8'd2);
        set_exp(1,  3'd3, 2'd0, 8'd2);
        set_exp(2,  3'd4, 2'd0, 8'd2);
        set_exp(3,  3'd3, 2'd0, 8'd2);
        set_exp(4,  3'd1, 2'd1, 8'd2);
        set_exp(5,  3'd3, 2'd1, 8'd2);
        set_exp(6,  3'd4, 2'd1, 8'd2);
        set_exp(7,  3'd2, 2'd1, 8'd0);
        set_exp(8,  3'd1, 2'd1, 8'd6);
        set_exp(9,  3'd3, 2'd1, 8'd6);
        set_exp(10, 3'd1, 2'd2, 8'd1);
        set_exp(11, 3'd3, 2'd2, 8'd1);
        set_exp(12, 3'd1, 2'd3, 8'd3);
        set_exp(13, 3'd4, 2'd3, 8'd3);
        cmp_seq(ref_i + 1, 14, "R7 drain order after refresh");

        // R11: the enqueue made while full is never served.
        ncol = 0;
        for (int i = ref_i + 1; i < log_n; i++)
            if (log_op[i] == 3'd3 || log_op[i] == 3'd4) ncol++;
        check_int(ncol, 8, "R11 dropped request not served");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule